// File: doc/BRIEF.md
# Byte-Window Bridge to a Word Memory

This block gives a host with only an 8-bit register bus a way into a 32-bit-wide internal memory. The host sees eight byte registers: an inbound mailbox, an outbound mailbox, a two-byte address pointer and four data bytes. Each data byte stands for one byte lane of the memory word that the pointer selects. A write to a data byte changes only that lane of the word. A read of a data byte returns that lane of the word.

The two lowest bits of the low address byte do not address bytes. They select an access type. One of the access types advances the pointer by one word each time the top data byte is touched. A host can therefore stream a buffer through the four data bytes without rewriting the address. It may start the stream at any lane. The inbound mailbox raises a sticky doorbell flag toward the internal side, and the internal side clears it with an acknowledge pulse. The outbound mailbox is a read-only view of a byte that the internal side drives.

Top module: `mem_window_bridge`

## Requirements
- R1: Offset 2 reads back the whole low address byte as written. Offset 3 reads back bits 6:0 as written, and its bit 7 always reads 0.
- R2: Bits 1:0 of the low address byte hold the access type: 0 byte, 1 half-word, 2 word, 3 word with auto-advance. Bits 7:2 are word address bits 7:2, and the high address byte bits 6:0 are address bits 14:8.
- R3: A host write to offset 4+k (k = 0..3) updates byte lane k (bits 8k+7:8k) of the addressed word and leaves the other three lanes unchanged.
- R4: A host read of offset 4+k returns byte lane k of the word the pointer addresses in that cycle, with no wait cycle.
- R5: With access type 3, a read or a write of offset 7 advances the word pointer by one after the access. The next data access uses the new word.
- R6: With access types 0, 1 or 2, an access to offset 7 leaves the pointer unchanged. With any access type, an access to offsets 4 to 6 leaves the pointer unchanged.
- R7: The memory holds 128 words, selected by address bits 8:2. Bits 14:9 do not select a word. An advance adds 1 modulo 128 to bits 8:2 and leaves bits 14:9 unchanged.
- R8: A host write to offset 0 stores the byte on the `h2cByte` output and sets `h2cPending` from the next cycle. A `h2cAck` pulse clears `h2cPending` unless an offset-0 write happens in the same cycle, in which case the flag stays set.
- R9: Offset 1 reads `c2hByte`. Host writes to offset 1 have no effect.
- R10: After reset, all registers and all memory words are zero, and the access type is 0 (byte).
- R11: A misaligned stream with access type 3 that starts at offset 6 and continues in the order 6, 7, 4, 5 fills lanes 2 and 3 of the start word and lanes 0 and 1 of the following word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Register offset 0 to 7 |
| hostWr | input | 1 | Host write strobe, one cycle per byte |
| hostRd | input | 1 | Host read strobe, one cycle per byte |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Read data for the selected offset, combinational |
| h2cByte | output | 8 | Last byte the host wrote to the inbound mailbox |
| h2cPending | output | 1 | Sticky doorbell toward the internal side |
| h2cAck | input | 1 | Internal acknowledge that clears the doorbell |
| c2hByte | input | 8 | Byte the internal side publishes at offset 1 |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. They also assume that the read data is only meaningful while a read strobe is high. Each bench task drives one strobe for one cycle and then returns both strobes to idle, so the host bus never sees a combined access. The access-type and pointer checks rely on the pointer changing only at the edge after an offset-2, offset-3 or offset-7 access. For that reason the bench reads the address registers back only in idle-separated cycles.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE     = 2'd0,
    ACC_HALF     = 2'd1,
    ACC_WORD     = 2'd2,
    ACC_WORD_INC = 2'd3
  } accType_e;

  localparam logic [2:0] OFF_H2C     = 3'd0;
  localparam logic [2:0] OFF_C2H     = 3'd1;
  localparam logic [2:0] OFF_ADDR_LO = 3'd2;
  localparam logic [2:0] OFF_ADDR_HI = 3'd3;
  localparam logic [2:0] OFF_DATA_TOP = 3'd7;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic       wrMbox;
    logic       wrAddrLo;
    logic       wrAddrHi;
    logic       wrData;
    logic       advance;
    logic [1:0] lane;
  } winCtrl_t;

endpackage

// File: rtl/mwb_ctrl.sv
module mwb_ctrl
  import mwb_pkg::*;
(
  input  logic [2:0] hostAddr,
  input  logic       hostWr,
  input  logic       hostRd,
  input  accType_e   accType,
  output winCtrl_t   ctrl
);

  logic touch;
  logic isData;

  assign touch  = hostWr | hostRd;
  assign isData = hostAddr[2];

  always_comb begin
    ctrl          = '0;
    ctrl.lane     = hostAddr[1:0];
    ctrl.wrMbox   = hostWr && (hostAddr == OFF_H2C);
    ctrl.wrAddrLo = hostWr && (hostAddr == OFF_ADDR_LO);
    ctrl.wrAddrHi = hostWr && (hostAddr == OFF_ADDR_HI);
    ctrl.wrData   = hostWr && isData;
    ctrl.advance  = touch && (hostAddr == OFF_DATA_TOP) && (accType == ACC_WORD_INC);
  end

endmodule

// File: rtl/mwb_datapath.sv
module mwb_datapath
  import mwb_pkg::*;
#(
  parameter int RAM_WORDS = 128,
  parameter int HI_BITS   = 7,
  localparam int IDX_W    = $clog2(RAM_WORDS),
  localparam int WADDR_W  = HI_BITS + 6
)(
  input  logic             clk,
  input  logic             rstN,
  input  winCtrl_t         ctrl,
  input  logic [2:0]       hostAddr,
  input  logic [7:0]       hostWdata,
  input  logic             h2cAck,
  input  logic [7:0]       c2hByte,
  output logic [7:0]       hostRdata,
  output logic [7:0]       h2cByte,
  output logic             h2cPending,
  output accType_e         accType,
  output logic [IDX_W-1:0] wordIdx
);

  logic [7:0]         addrLo;
  logic [HI_BITS-1:0] addrHi;
  logic [WADDR_W-1:0] wordAddr;
  logic [WADDR_W-1:0] nextWord;
  logic [IDX_W-1:0]   nextIdx;
  logic [31:0]        mem [RAM_WORDS];
  logic [31:0]        curWord;

  assign wordAddr = {addrHi, addrLo[7:2]};
  assign wordIdx  = wordAddr[IDX_W-1:0];
  assign nextIdx  = wordIdx + 1'b1;
  assign nextWord = {wordAddr[WADDR_W-1:IDX_W], nextIdx};
  assign accType  = accType_e'(addrLo[1:0]);
  assign curWord  = mem[wordIdx];

  // pointer and access-type register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLo <= '0;
      addrHi <= '0;
    end else if (ctrl.wrAddrLo) begin
      addrLo <= hostWdata;
    end else if (ctrl.wrAddrHi) begin
      addrHi <= hostWdata[HI_BITS-1:0];
    end else if (ctrl.advance) begin
      addrLo[7:2] <= nextWord[5:0];
      addrHi      <= nextWord[WADDR_W-1:6];
    end
  end

  // doorbell mailbox
  always_ff @(posedge clk) begin
    if (!rstN) begin
      h2cByte    <= '0;
      h2cPending <= 1'b0;
    end else if (ctrl.wrMbox) begin
      h2cByte    <= hostWdata;
      h2cPending <= 1'b1;
    end else if (h2cAck) begin
      h2cPending <= 1'b0;
    end
  end

  // word store with byte-lane write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < RAM_WORDS; w++) mem[w] <= '0;
    end else if (ctrl.wrData) begin
      mem[wordIdx][ctrl.lane*8 +: 8] <= hostWdata;
    end
  end

  always_comb begin
    case (hostAddr)
      OFF_H2C:     hostRdata = h2cByte;
      OFF_C2H:     hostRdata = c2hByte;
      OFF_ADDR_LO: hostRdata = addrLo;
      OFF_ADDR_HI: hostRdata = 8'({1'b0, addrHi});
      default:     hostRdata = curWord[hostAddr[1:0]*8 +: 8];
    endcase
  end

endmodule

// File: rtl/mem_window_bridge.sv
module mem_window_bridge
  import mwb_pkg::*;
#(
  parameter int RAM_WORDS = 128,
  localparam int IDX_W    = $clog2(RAM_WORDS)
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hostAddr,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  output logic [7:0] h2cByte,
  output logic       h2cPending,
  input  logic       h2cAck,
  input  logic [7:0] c2hByte
);

  winCtrl_t         ctrl;
  accType_e         accType;
  logic [IDX_W-1:0] wordIdx;

  mwb_ctrl u_ctrl (
    .hostAddr (hostAddr),
    .hostWr   (hostWr),
    .hostRd   (hostRd),
    .accType  (accType),
    .ctrl     (ctrl)
  );

  mwb_datapath #(.RAM_WORDS(RAM_WORDS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .h2cAck     (h2cAck),
    .c2hByte    (c2hByte),
    .hostRdata  (hostRdata),
    .h2cByte    (h2cByte),
    .h2cPending (h2cPending),
    .accType    (accType),
    .wordIdx    (wordIdx)
  );

endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
  parameter int IDX_W = 7
)(
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       hostAddr,
  input logic             hostWr,
  input logic             hostRd,
  input logic [7:0]       hostWdata,
  input logic [7:0]       hostRdata,
  input logic             h2cPending,
  input logic             h2cAck,
  input logic [7:0]       c2hByte,
  input logic [1:0]       accType,
  input logic [IDX_W-1:0] wordIdx
);

  a_in_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr && hostRd));

  a_r8_doorbell_set: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 3'd0) |=> h2cPending);

  a_r8_doorbell_clear: assert property (@(posedge clk) disable iff (!rstN)
    (h2cAck && !(hostWr && hostAddr == 3'd0)) |=> !h2cPending);

  a_r9_c2h_mirror: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 3'd1) |-> hostRdata == c2hByte);

  a_r5_advance: assert property (@(posedge clk) disable iff (!rstN)
    ((hostWr || hostRd) && hostAddr == 3'd7 && accType == 2'd3)
      |=> wordIdx == IDX_W'($past(wordIdx) + 1'b1));

  a_r6_no_advance: assert property (@(posedge clk) disable iff (!rstN)
    ((hostWr || hostRd) && hostAddr[2] && !(hostAddr == 3'd7 && accType == 2'd3))
      |=> $stable(wordIdx));

  a_r2_type_load: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 3'd2) |=> accType == $past(hostWdata[1:0]));

endmodule

bind mem_window_bridge mwb_checker #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostAddr   (hostAddr),
  .hostWr     (hostWr),
  .hostRd     (hostRd),
  .hostWdata  (hostWdata),
  .hostRdata  (hostRdata),
  .h2cPending (h2cPending),
  .h2cAck     (h2cAck),
  .c2hByte    (c2hByte),
  .accType    (accType),
  .wordIdx    (wordIdx)
);

// File: tb/sim_mem_window_bridge.sv
`timescale 1ns/1ps
module sim_mem_window_bridge;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [7:0] h2cByte;
  logic       h2cPending;
  logic       h2cAck = 1'b0;
  logic [7:0] c2hByte = '0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mem_window_bridge u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .h2cByte(h2cByte), .h2cPending(h2cPending), .h2cAck(h2cAck),
    .c2hByte(c2hByte)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] off, input logic [7:0] val);
    @(negedge clk);
    hostAddr = off; hostWdata = val; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] off, output logic [7:0] val);
    @(negedge clk);
    hostAddr = off; hostRd = 1'b1;
    #1 val = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic expectRead(input string req, input logic [2:0] off, input logic [7:0] exp);
    logic [7:0] v;
    hostRead(off, v);
    check(req, v, exp);
  endtask

  task automatic test_reset;
    check("R10 pending", {7'd0, h2cPending}, 8'h00);
    check("R10 h2cByte", h2cByte, 8'h00);
    for (int o = 0; o < 8; o++)
      if (o != 1) expectRead("R10 reg zero", 3'(o), 8'h00);
  endtask

  task automatic test_addr_regs;
    hostWrite(3'd2, 8'hA7);
    expectRead("R1 lo readback", 3'd2, 8'hA7);
    hostWrite(3'd3, 8'hFF);
    expectRead("R1 hi bit7 zero", 3'd3, 8'h7F);
    hostWrite(3'd3, 8'h00);
    expectRead("R2 hi cleared", 3'd3, 8'h00);
  endtask

  task automatic test_lanes;
    hostWrite(3'd2, 8'h14); // word 5, byte type
    hostWrite(3'd5, 8'h3C);
    expectRead("R3 lane0 untouched", 3'd4, 8'h00);
    expectRead("R4 lane1", 3'd5, 8'h3C);
    expectRead("R3 lane2 untouched", 3'd6, 8'h00);
    expectRead("R3 lane3 untouched", 3'd7, 8'h00);
    hostWrite(3'd4, 8'h11);
    expectRead("R3 lane1 kept", 3'd5, 8'h3C);
    expectRead("R4 lane0", 3'd4, 8'h11);
    expectRead("R6 byte type no move", 3'd2, 8'h14);
  endtask

  task automatic test_autoinc;
    hostWrite(3'd2, 8'h2B); // word 10, auto-advance
    hostWrite(3'd4, 8'h01);
    hostWrite(3'd5, 8'h02);
    hostWrite(3'd6, 8'h03);
    expectRead("R6 offset6 no move", 3'd2, 8'h2B);
    hostWrite(3'd7, 8'h04);
    expectRead("R5 write advance", 3'd2, 8'h2F);
    hostWrite(3'd2, 8'h2B);
    expectRead("R4 word10 lane0", 3'd4, 8'h01);
    expectRead("R4 word10 lane3", 3'd7, 8'h04);
    expectRead("R5 read advance", 3'd2, 8'h2F);
    expectRead("R5 next word", 3'd4, 8'h00);
    hostWrite(3'd2, 8'h2A); // word 10, plain word type
    expectRead("R6 word type lane3", 3'd7, 8'h04);
    expectRead("R6 word type no move", 3'd2, 8'h2A);
    hostWrite(3'd2, 8'h29); // half-word type
    expectRead("R6 half type lane3", 3'd7, 8'h04);
    expectRead("R6 half type no move", 3'd2, 8'h29);
  endtask

  task automatic test_wrap;
    hostWrite(3'd3, 8'h05);
    hostWrite(3'd2, 8'hFF); // index 127, upper bits 0x04
    hostWrite(3'd7, 8'h99);
    expectRead("R7 wrap lo", 3'd2, 8'h03);
    expectRead("R7 wrap hi keeps upper", 3'd3, 8'h04);
    hostWrite(3'd3, 8'h01);
    hostWrite(3'd2, 8'hFC); // index 127, upper bits 0
    expectRead("R7 upper bits alias", 3'd7, 8'h99);
    hostWrite(3'd3, 8'h00);
  endtask

  task automatic test_doorbell;
    hostWrite(3'd0, 8'h5A);
    check("R8 pending set", {7'd0, h2cPending}, 8'h01);
    check("R8 byte out", h2cByte, 8'h5A);
    expectRead("R8 readback", 3'd0, 8'h5A);
    @(negedge clk); h2cAck = 1'b1;
    @(negedge clk); h2cAck = 1'b0;
    check("R8 ack clears", {7'd0, h2cPending}, 8'h00);
    @(negedge clk);
    hostAddr = 3'd0; hostWdata = 8'h66; hostWr = 1'b1; h2cAck = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; h2cAck = 1'b0;
    check("R8 write beats ack", {7'd0, h2cPending}, 8'h01);
  endtask

  task automatic test_c2h;
    c2hByte = 8'hC3;
    expectRead("R9 c2h read", 3'd1, 8'hC3);
    hostWrite(3'd1, 8'h00);
    expectRead("R9 write ignored", 3'd1, 8'hC3);
    c2hByte = 8'h3E;
    expectRead("R9 follows input", 3'd1, 8'h3E);
  endtask

  task automatic test_misaligned;
    hostWrite(3'd2, 8'h53); // word 20, auto-advance
    hostWrite(3'd6, 8'hAA);
    hostWrite(3'd7, 8'hBB);
    hostWrite(3'd4, 8'hCC);
    hostWrite(3'd5, 8'hDD);
    expectRead("R11 pointer at word21", 3'd2, 8'h57);
    hostWrite(3'd2, 8'h53);
    expectRead("R11 lane2", 3'd6, 8'hAA);
    expectRead("R11 lane3", 3'd7, 8'hBB);
    expectRead("R11 next lane0", 3'd4, 8'hCC);
    expectRead("R11 next lane1", 3'd5, 8'hDD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_addr_regs();
    test_lanes();
    test_autoinc();
    test_wrap();
    test_doorbell();
    test_c2h();
    test_misaligned();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule